// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a presettable binary counter, 4 bits wide by default, that counts up or down. Every change to its value happens on the rising clock edge. On that edge the block does one of five things: clear, parallel preset, step up, step down or hold. Which one it does is fixed by the control inputs sampled at that edge, and nothing changes between edges.

Two active-low enables gate counting: a plain count enable and a chain enable. Only the chain enable reaches the carry. The active-low carry output goes low for one count state when the chain enable is low and the counter sits at its terminal value. That value is all ones when counting up and all zeros when counting down. If the carry of one stage drives the chain enable of the next, identical stages chain into a wider synchronous counter with no added gates.

The operation is chosen by an enumerated mode with five states. MODE_CLEAR is taken when `srst` is high. MODE_PRESET is taken when `preset_n` is low. MODE_STEP_UP and MODE_STEP_DOWN are taken when both enables are low, with the direction set by `count_up`. MODE_HOLD covers everything else. The transitions between count values follow from these: clear goes to 0, preset goes to `din`, a step up adds one and wraps from the top value to 0, a step down subtracts one and wraps from 0 to the top value, and hold keeps the value. `srst` outranks preset, and preset outranks counting.

Top module: `updown_cascade_counter`

## Requirements
- R1: When `srst` is high at a rising edge, `count` becomes 0 on that edge, whatever the other inputs are, including a low `preset_n`.
- R2: When `srst` is low and `preset_n` is low at a rising edge, `count` takes `din` on that edge, whatever the enables and direction are.
- R3: When `srst` is low, `preset_n` is high, `cnt_en_n` and `chain_en_n` are both low and `count_up` is 1, `count` increases by one on the edge, wrapping from all ones to 0.
- R4: Under the same conditions with `count_up` at 0, `count` decreases by one on the edge, wrapping from 0 to all ones.
- R5: When `srst` is low, `preset_n` is high and either `cnt_en_n` or `chain_en_n` is high, `count` keeps its value.
- R6: `carry_n` is low exactly when `chain_en_n` is low and `count` is at its terminal value. The terminal value is all ones when `count_up` is 1 and 0 when `count_up` is 0. `carry_n` follows its inputs combinationally, within the same cycle.
- R7: `cnt_en_n` has no effect on `carry_n`. With `cnt_en_n` high the count is frozen, but the carry still follows R6.
- R8: Two stages chained, with the lower stage's `carry_n` driving the upper stage's `chain_en_n` and the other inputs shared, count as one counter of twice the width in both directions, including the wrap at both ends.
- R9: Changes on `preset_n`, `din` or the enables between rising edges have no effect on `count`. Only the levels present at a rising edge matter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| srst | input | 1 | Synchronous active-high clear, highest priority |
| preset_n | input | 1 | Synchronous active-low parallel preset |
| cnt_en_n | input | 1 | Active-low count enable; does not affect the carry |
| chain_en_n | input | 1 | Active-low count enable that also gates the carry |
| count_up | input | 1 | 1 counts up, 0 counts down |
| din | input | WIDTH (4) | Preset value |
| count | output | WIDTH (4) | Current count |
| carry_n | output | 1 | Active-low terminal-count carry for cascading |

## Verification
The bench chains two stages and sweeps more than a full 8-bit cycle upward and then downward against an arithmetic reference, which covers every wrap at both the stage boundary and the top and bottom of the combined range. A carry that ignores the direction or the chain enable would let the upper stage step at the wrong boundaries or on every cycle, and the combined value would then diverge. Holds are tested with each enable raised on its own; a carry wrongly gated by the count enable would stay high while frozen at the terminal value. Presets held against active enables, a clear asserted together with a preset, and a preset pulse that ends before the edge catch wrong priority and any asynchronous path.

// File: rtl/ucc_pkg.sv
package ucc_pkg;

    typedef enum logic [2:0] {
        MODE_HOLD      = 3'd0,
        MODE_CLEAR     = 3'd1,
        MODE_PRESET    = 3'd2,
        MODE_STEP_UP   = 3'd3,
        MODE_STEP_DOWN = 3'd4
    } ucc_mode_t;

endpackage

// File: rtl/ucc_mode_sel.sv
module ucc_mode_sel
    import ucc_pkg::*;
(
    input  logic      srst,
    input  logic      preset_n,
    input  logic      cnt_en_n,
    input  logic      chain_en_n,
    input  logic      count_up,
    output ucc_mode_t mode
);

    logic step_ok;

    always_comb begin
        step_ok = ~cnt_en_n & ~chain_en_n;
        if (srst) begin
            mode = MODE_CLEAR;
        end else if (!preset_n) begin
            mode = MODE_PRESET;
        end else if (step_ok) begin
            mode = count_up ? MODE_STEP_UP : MODE_STEP_DOWN;
        end else begin
            mode = MODE_HOLD;
        end
    end

endmodule

// File: rtl/ucc_next_count.sv
module ucc_next_count
    import ucc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  ucc_mode_t         mode,
    input  logic [WIDTH-1:0]  cur,
    input  logic [WIDTH-1:0]  din,
    output logic [WIDTH-1:0]  nxt
);

    // Per-bit toggle masks, each bit decided from all lower bits at once.
    logic [WIDTH-1:0] flip_up;
    logic [WIDTH-1:0] flip_dn;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_flip
            if (i == 0) begin : g_lsb
                assign flip_up[i] = 1'b1;
                assign flip_dn[i] = 1'b1;
            end else begin : g_upper
                assign flip_up[i] = &cur[i-1:0];
                assign flip_dn[i] = ~|cur[i-1:0];
            end
        end
    endgenerate

    always_comb begin
        unique case (mode)
            MODE_CLEAR:     nxt = '0;
            MODE_PRESET:    nxt = din;
            MODE_STEP_UP:   nxt = cur ^ flip_up;
            MODE_STEP_DOWN: nxt = cur ^ flip_dn;
            MODE_HOLD:      nxt = cur;
            default:        nxt = cur;
        endcase
    end

endmodule

// File: rtl/ucc_carry_out.sv
module ucc_carry_out #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             count_up,
    input  logic             chain_en_n,
    output logic             carry_n
);

    logic at_end;

    always_comb begin
        // All bits equal the direction bit: all ones going up, all zeros going down.
        at_end  = &(cur ~^ {WIDTH{count_up}});
        carry_n = ~(at_end & ~chain_en_n);
    end

endmodule

// File: rtl/updown_cascade_counter.sv
module updown_cascade_counter
    import ucc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             preset_n,
    input  logic             cnt_en_n,
    input  logic             chain_en_n,
    input  logic             count_up,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             carry_n
);

    localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

    ucc_mode_t        mode;
    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] count_d;

    ucc_mode_sel u_mode_sel (
        .srst       (srst),
        .preset_n   (preset_n),
        .cnt_en_n   (cnt_en_n),
        .chain_en_n (chain_en_n),
        .count_up   (count_up),
        .mode       (mode)
    );

    ucc_next_count #(.WIDTH(WIDTH)) u_next_count (
        .mode (mode),
        .cur  (count_q),
        .din  (din),
        .nxt  (count_d)
    );

    ucc_carry_out #(.WIDTH(WIDTH)) u_carry_out (
        .cur        (count_q),
        .count_up   (count_up),
        .chain_en_n (chain_en_n),
        .carry_n    (carry_n)
    );

    // State register
    always_ff @(posedge clk) begin
        count_q <= count_d;
    end

    // Outputs
    always_comb begin
        count = count_q;
    end

    assert_clear_R1: assert property (@(posedge clk) disable iff (1'b0)
        srst |=> count == '0);

    assert_preset_R2: assert property (@(posedge clk) disable iff (srst)
        !preset_n |=> count == $past(din));

    assert_step_up_R3: assert property (@(posedge clk) disable iff (srst)
        (preset_n && !cnt_en_n && !chain_en_n && count_up)
        |=> count == $past(count) + 1'b1);

    assert_step_down_R4: assert property (@(posedge clk) disable iff (srst)
        (preset_n && !cnt_en_n && !chain_en_n && !count_up)
        |=> count == $past(count) - 1'b1);

    assert_hold_R5: assert property (@(posedge clk) disable iff (srst)
        (preset_n && (cnt_en_n || chain_en_n)) |=> $stable(count));

    assert_carry_terminal_R6: assert property (@(posedge clk) disable iff (srst)
        !carry_n |-> (!chain_en_n && (count_up ? count == TOP_VAL : count == '0)));

    assert_carry_needs_chain_R6: assert property (@(posedge clk) disable iff (srst)
        chain_en_n |-> carry_n);

endmodule

// File: tb/updown_cascade_counter_bench.sv
module updown_cascade_counter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         srst;
    logic         preset_n;
    logic         cnt_en_n;
    logic         chain_lo_n;
    logic         count_up;
    logic [7:0]   dval;
    logic [W-1:0] q_lo, q_hi;
    logic         c_lo_n, c_hi_n;

    int checks = 0;
    int fails  = 0;
    logic [7:0] ref_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    updown_cascade_counter #(.WIDTH(W)) u_updown_cascade_counter (
        .clk(clk), .srst(srst), .preset_n(preset_n), .cnt_en_n(cnt_en_n),
        .chain_en_n(chain_lo_n), .count_up(count_up), .din(dval[3:0]),
        .count(q_lo), .carry_n(c_lo_n)
    );

    updown_cascade_counter #(.WIDTH(W)) u_updown_cascade_counter_hi (
        .clk(clk), .srst(srst), .preset_n(preset_n), .cnt_en_n(cnt_en_n),
        .chain_en_n(c_lo_n), .count_up(count_up), .din(dval[7:4]),
        .count(q_hi), .carry_n(c_hi_n)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic carry_of(input logic [3:0] v, input logic up, input logic chain_n);
        logic term;
        term = up ? (v == 4'hF) : (v == 4'h0);
        return !(term && !chain_n);
    endfunction

    // Called just after a falling edge; drives, checks carries, then checks count next falling edge.
    task automatic tick(input string tag, input logic r, input logic pn, input logic en,
                        input logic ce, input logic up, input logic [7:0] dv);
        logic exp_lo_c;
        srst = r; preset_n = pn; cnt_en_n = en; chain_lo_n = ce; count_up = up; dval = dv;
        #1;
        exp_lo_c = carry_of(ref_q[3:0], up, ce);
        check({tag, " R6 R7 carry lo"}, {7'd0, c_lo_n}, {7'd0, exp_lo_c});
        check({tag, " R6 R8 carry hi"}, {7'd0, c_hi_n}, {7'd0, carry_of(ref_q[7:4], up, exp_lo_c)});
        if (r)            ref_q = 8'h00;
        else if (!pn)     ref_q = dv;
        else if (!en && !ce) ref_q = up ? ref_q + 8'd1 : ref_q - 8'd1;
        @(negedge clk);
        check({tag, " count"}, {q_hi, q_lo}, ref_q);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        srst = 1'b1; preset_n = 1'b1; cnt_en_n = 1'b1; chain_lo_n = 1'b1;
        count_up = 1'b1; dval = 8'h00; ref_q = 8'h00;
        @(negedge clk);
        // R1 reset state, with preset also requested
        tick("R1 clear over preset", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5);
        tick("R1 clear", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        // R3 R8 full up sweep through 255 -> 0
        for (int k = 0; k < 300; k++) tick("R3 R8 up", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        // R4 R8 full down sweep through 0 -> 255
        for (int k = 0; k < 300; k++) tick("R4 R8 down", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        // R2 presets with enables active, several patterns
        for (int k = 0; k < 8; k++) begin
            tick("R2 preset", 1'b0, 1'b0, 1'b0, 1'b0, k[0], 8'(k * 37 + 15));
            tick("R3 R4 after preset", 1'b0, 1'b1, 1'b0, 1'b0, k[1], 8'h00);
        end
        // R5 hold with count enable high at terminal; R7 carry still live
        tick("R2 preset 0F", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h0F);
        for (int k = 0; k < 4; k++) tick("R5 R7 hold en", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        for (int k = 0; k < 4; k++) tick("R5 hold chain", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
        tick("R2 preset F0", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hF0);
        for (int k = 0; k < 4; k++) tick("R5 R7 hold down", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        tick("R4 R8 borrow", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        // R9 preset pulse between edges has no effect
        srst = 1'b0; cnt_en_n = 1'b1; chain_lo_n = 1'b1;
        dval = 8'h3C; preset_n = 1'b0;
        #2;
        preset_n = 1'b1; cnt_en_n = 1'b0; chain_lo_n = 1'b0;
        #1;
        cnt_en_n = 1'b1;
        check("R9 mid-cycle", {q_hi, q_lo}, ref_q);
        @(negedge clk);
        check("R9 after edge", {q_hi, q_lo}, ref_q);
        tick("R1 final clear", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule